// File: doc/BRIEF.md
# Fast CPU Reset and A20 Gate Control Register

This block is a single 8-bit control register that the host reaches through a generic chip-select, read-strobe and write-strobe port. Its base address is a parameter and defaults to 92h. Software uses it for two things. It can drive an alternate A20 gate line directly. It can also request a CPU reset that is faster than the one the keyboard controller gives. The A20 bit is ORed with the keyboard controller's gate to form the final gate output. The reset request is a low pulse that is ANDed with the keyboard controller's active-low reset. The combined reset then passes through a polarity select.

The reset request is a one-shot. When a write turns the reset bit from 0 to 1 while the enable input is high, a sequencer arms. It waits a fixed delay and then drives a fixed-width low pulse. The sequencer has three states. `SEQ_IDLE` moves to `SEQ_WAIT` on an arm request. `SEQ_WAIT` moves to `SEQ_FIRE` when its cycle count reaches `DELAY_CYC`. `SEQ_FIRE` returns to `SEQ_IDLE` when its cycle count reaches `PULSE_CYC`. Both counts come from clock frequency and time parameters. The defaults are 700 and 300 cycles at 50 MHz, which is 14 us and 6 us. Once started, a sequence always runs to the end. No further pulse is possible until the reset bit has gone back to 0.

Top module: `fast_rst_a20`

## Requirements
- R1: A read that selects the base address returns the register on `rdata` in the same cycle. The layout is bit 0 = reset bit, bit 1 = A20 bit, bits 2 and 5 = 1, and bits 3, 4, 6 and 7 = 0. After reset the value is 24h. `rdata` is 00h whenever no read selects the base address.
- R2: A write to any other address changes nothing. Write data on bits 7:2 has no effect on the value read back.
- R3: Bit 1 stores the written value, and `gate_out` equals `kbc_gate` OR bit 1. `gate_out` is low only when both are 0.
- R4: System reset clears bit 0. While the sequencer is in `SEQ_IDLE` and `kbc_rst_n` is high, the reset output is at its inactive level.
- R5: A write that takes bit 0 from 0 to 1 while `fast_rst_en` is high starts a pulse. The internal active-low pulse begins exactly `DELAY_CYC` clock cycles after the write's clock edge. It stays low for exactly `PULSE_CYC` cycles.
- R6: Writing 1 to bit 0 while it already holds 1 produces no pulse. Once a write has cleared it to 0, the next 0-to-1 write produces a new pulse.
- R7: While `fast_rst_en` is low, a 0-to-1 write of bit 0 stores the bit but produces no pulse.
- R8: Clearing bit 0 during `SEQ_WAIT` or `SEQ_FIRE` neither shortens nor cancels the sequence.
- R9: A 0-to-1 write of bit 0 made while the sequencer is busy starts no second sequence.
- R10: `sys_rst_out` is the AND of the internal pulse and `kbc_rst_n`, both active-low. With `rst_pol_hi` = 0 it is output unchanged (active low). With `rst_pol_hi` = 1 it is inverted (active high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| cs | input | 1 | Chip select for the host access |
| wr | input | 1 | Write strobe, sampled on the clock edge |
| rd | input | 1 | Read strobe |
| addr | input | ADDR_W | Host I/O address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| fast_rst_en | input | 1 | Enable for the reset pulse (from configuration) |
| kbc_rst_n | input | 1 | Keyboard-controller reset, active low |
| kbc_gate | input | 1 | Keyboard-controller A20 gate |
| rst_pol_hi | input | 1 | 1 makes the reset output active high |
| sys_rst_out | output | 1 | Combined CPU reset output |
| gate_out | output | 1 | Combined A20 gate output |

## Verification
Read data and the combined outputs follow their inputs within the same cycle. The bench samples them one nanosecond after driving the inputs at a falling edge. A stored bit appears at the first falling edge after the write's rising edge. The reset pulse is due to begin exactly `DELAY_CYC` rising edges after that write edge and to last `PULSE_CYC` cycles. A monitor samples `sys_rst_out` two nanoseconds after each falling edge against a free-running edge counter. It records the edge number of the first active sample and the length of the pulse. Each test compares these against the counter value recorded at its write, so an early, late, short, long or missing pulse is reported.

// File: rtl/frst_pkg.sv
package frst_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_FIRE = 2'd2
    } seq_state_t;

    // bit positions decoded by the register and the sequencer
    localparam int BIT_RST = 0;
    localparam int BIT_A20 = 1;

    // constant pattern returned in the reserved positions
    localparam logic [7:0] FIXED_VAL  = 8'h24;
    localparam logic [7:0] FIXED_MASK = 8'hFC;

endpackage

// File: rtl/frst_regs.sv
module frst_regs
    import frst_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE   = 16'h0092
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              fast_rst_en,
    output logic [7:0]        rdata,
    output logic              a20_q,
    output logic              rstbit_q,
    output logic              arm
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE);

    logic addr_hit;
    logic wr_hit;
    logic rd_hit;

    always_comb begin
        addr_hit = (addr == MY_ADDR);
        wr_hit   = cs && wr && addr_hit;
        rd_hit   = cs && rd && addr_hit;
    end

    // storage for the two writable bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a20_q    <= 1'b0;
            rstbit_q <= 1'b0;
        end else if (wr_hit) begin
            a20_q    <= wdata[BIT_A20];
            rstbit_q <= wdata[BIT_RST];
        end
    end

    // a 0-to-1 write of the reset bit with the enable high requests a pulse
    always_comb begin
        arm = wr_hit && wdata[BIT_RST] && !rstbit_q && fast_rst_en;
    end

    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            rdata          = FIXED_VAL & FIXED_MASK;
            rdata[BIT_A20] = a20_q;
            rdata[BIT_RST] = rstbit_q;
        end
    end

endmodule

// File: rtl/frst_seq.sv
module frst_seq
    import frst_pkg::*;
#(
    parameter int DELAY_CYC = 700,
    parameter int PULSE_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic pulse_n,
    output logic busy
);

    localparam int MAX_CYC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(DELAY_CYC - 1);
    localparam logic [CNT_W-1:0] FIRE_LAST = CNT_W'(PULSE_CYC - 1);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (arm)                state_d = SEQ_WAIT;
            SEQ_WAIT: if (cnt_q == WAIT_LAST) state_d = SEQ_FIRE;
            SEQ_FIRE: if (cnt_q == FIRE_LAST) state_d = SEQ_IDLE;
            default:                          state_d = SEQ_IDLE;
        endcase
    end

    // state register and the shared phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || state_q == SEQ_IDLE) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs decoded from the state register
    always_comb begin
        pulse_n = 1'b1;
        busy    = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                pulse_n = 1'b1;
                busy    = 1'b0;
            end
            SEQ_WAIT: begin
                pulse_n = 1'b1;
                busy    = 1'b1;
            end
            SEQ_FIRE: begin
                pulse_n = 1'b0;
                busy    = 1'b1;
            end
            default: begin
                pulse_n = 1'b1;
                busy    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/frst_outmux.sv
module frst_outmux (
    input  logic pulse_n,
    input  logic kbc_rst_n,
    input  logic rst_pol_hi,
    input  logic a20_q,
    input  logic kbc_gate,
    output logic sys_rst_out,
    output logic gate_out
);

    logic merged_n;

    always_comb begin
        merged_n    = pulse_n & kbc_rst_n;
        sys_rst_out = rst_pol_hi ? ~merged_n : merged_n;
        gate_out    = kbc_gate | a20_q;
    end

endmodule

// File: rtl/fast_rst_a20.sv
module fast_rst_a20
    import frst_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] BASE     = 16'h0092,
    parameter int          CLK_KHZ  = 50_000,
    parameter int          DELAY_NS = 14_000,
    parameter int          PULSE_NS = 6_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              fast_rst_en,
    input  logic              kbc_rst_n,
    input  logic              kbc_gate,
    input  logic              rst_pol_hi,
    output logic              sys_rst_out,
    output logic              gate_out
);

    localparam int DELAY_RAW = (CLK_KHZ * DELAY_NS) / 1_000_000;
    localparam int PULSE_RAW = (CLK_KHZ * PULSE_NS) / 1_000_000;
    localparam int DELAY_CYC = (DELAY_RAW < 1) ? 1 : DELAY_RAW;
    localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : PULSE_RAW;

    logic a20_q;
    logic rstbit_q;
    logic arm;
    logic pulse_n;
    logic seq_busy;

    frst_regs #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs          (cs),
        .wr          (wr),
        .rd          (rd),
        .addr        (addr),
        .wdata       (wdata),
        .fast_rst_en (fast_rst_en),
        .rdata       (rdata),
        .a20_q       (a20_q),
        .rstbit_q    (rstbit_q),
        .arm         (arm)
    );

    frst_seq #(
        .DELAY_CYC (DELAY_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .pulse_n (pulse_n),
        .busy    (seq_busy)
    );

    frst_outmux u_out (
        .pulse_n     (pulse_n),
        .kbc_rst_n   (kbc_rst_n),
        .rst_pol_hi  (rst_pol_hi),
        .a20_q       (a20_q),
        .kbc_gate    (kbc_gate),
        .sys_rst_out (sys_rst_out),
        .gate_out    (gate_out)
    );

endmodule

// File: rtl/fast_rst_a20_chk.sv
module fast_rst_a20_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE      = 16'h0092,
    parameter int          DELAY_CYC = 700,
    parameter int          PULSE_CYC = 300
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              wr,
    input logic              rd,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic              fast_rst_en,
    input logic              kbc_rst_n,
    input logic              kbc_gate,
    input logic              rst_pol_hi,
    input logic              sys_rst_out,
    input logic              gate_out,
    input logic              pulse_n,
    input logic              seq_busy,
    input logic              rstbit_q,
    input logic              a20_q
);

    logic sel;
    logic wsel;
    logic [31:0] low_run;
    logic [31:0] wait_run;

    always_comb begin
        sel  = cs && (addr == ADDR_W'(BASE));
        wsel = sel && wr;
    end

    // run-length counters for the waiting phase and the low phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run  <= '0;
            wait_run <= '0;
        end else begin
            low_run  <= !pulse_n ? low_run + 1 : '0;
            wait_run <= (seq_busy && pulse_n) ? wait_run + 1 : '0;
        end
    end

    a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd) |-> ((rdata & 8'hFC) == 8'h24));

    a_r3_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!kbc_gate && !a20_q) |-> !gate_out);

    a_r3_gate_kbc: assert property (@(posedge clk) disable iff (!rst_n)
        kbc_gate |-> gate_out);

    a_r4_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && kbc_rst_n) |-> (sys_rst_out != rst_pol_hi));

    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_n) |-> (low_run == PULSE_CYC));

    a_r5_pulse_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_n) |-> (wait_run == DELAY_CYC));

    a_r6_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel && wdata[0] && rstbit_q && !seq_busy) |=> !seq_busy);

    a_r7_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel && !fast_rst_en && !seq_busy) |=> !seq_busy);

    a_r10_kbc_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !kbc_rst_n |-> (sys_rst_out == rst_pol_hi));

endmodule

bind fast_rst_a20 fast_rst_a20_chk #(
    .ADDR_W    (ADDR_W),
    .BASE      (BASE),
    .DELAY_CYC (DELAY_CYC),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs          (cs),
    .wr          (wr),
    .rd          (rd),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .fast_rst_en (fast_rst_en),
    .kbc_rst_n   (kbc_rst_n),
    .kbc_gate    (kbc_gate),
    .rst_pol_hi  (rst_pol_hi),
    .sys_rst_out (sys_rst_out),
    .gate_out    (gate_out),
    .pulse_n     (pulse_n),
    .seq_busy    (seq_busy),
    .rstbit_q    (rstbit_q),
    .a20_q       (a20_q)
);

// File: tb/sim_fast_rst_a20.sv
`timescale 1ns/1ps
module sim_fast_rst_a20;

    localparam int DLY = 700;   // 14 us at 50 MHz
    localparam int PW  = 300;   // 6 us at 50 MHz
    localparam logic [15:0] REG_A = 16'h0092;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        fast_rst_en = 1'b1;
    logic        kbc_rst_n = 1'b1;
    logic        kbc_gate = 1'b0;
    logic        rst_pol_hi = 1'b0;
    logic        sys_rst_out;
    logic        gate_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wr_cyc = 0;
    int low_cnt = 0;
    int pulse_cnt = 0;
    int first_low = -1;
    logic prev_act = 1'b0;

    always #10 clk = ~clk;

    fast_rst_a20 u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
        .wdata(wdata), .rdata(rdata), .fast_rst_en(fast_rst_en),
        .kbc_rst_n(kbc_rst_n), .kbc_gate(kbc_gate), .rst_pol_hi(rst_pol_hi),
        .sys_rst_out(sys_rst_out), .gate_out(gate_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // pulse monitor: samples away from both edges
    always begin
        @(negedge clk);
        #2;
        begin
            logic act;
            act = rst_pol_hi ? sys_rst_out : !sys_rst_out;
            if (act) begin
                if (low_cnt == 0 && first_low < 0) first_low = cyc;
                low_cnt++;
                if (!prev_act) pulse_cnt++;
            end
            prev_act = act;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_cyc = cyc;
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic host_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        #1;
        d = rdata;
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk);
        #3;
        low_cnt = 0; pulse_cnt = 0; first_low = -1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        host_rd(REG_A, d);
        chk("R1", "reset readback", d, 8'h24);
        #1;
        chk("R4", "reset output idle", sys_rst_out, 1);
        chk("R3", "gate after reset", gate_out, 0);
        host_rd(16'h0093, d);
        chk("R1", "unselected read", d, 0);
    endtask

    task automatic t_reserved_and_decode();
        logic [7:0] d;
        host_wr(REG_A, 8'hFC);
        host_rd(REG_A, d);
        chk("R2", "reserved write ignored", d, 8'h24);
        host_wr(16'h0093, 8'h03);
        host_rd(REG_A, d);
        chk("R2", "other address ignored", d, 8'h24);
        host_wr(16'h0192, 8'h02);
        host_rd(REG_A, d);
        chk("R2", "upper address bits decoded", d, 8'h24);
    endtask

    task automatic t_gate();
        logic [7:0] d;
        kbc_gate = 1'b0;
        host_wr(REG_A, 8'h02);
        host_rd(REG_A, d);
        chk("R3", "a20 bit readback", d, 8'h26);
        chk("R3", "gate a20=1 kbc=0", gate_out, 1);
        @(negedge clk); kbc_gate = 1'b1; #1;
        chk("R3", "gate a20=1 kbc=1", gate_out, 1);
        host_wr(REG_A, 8'h00);
        #1;
        chk("R3", "gate a20=0 kbc=1", gate_out, 1);
        @(negedge clk); kbc_gate = 1'b0; #1;
        chk("R3", "gate a20=0 kbc=0", gate_out, 0);
    endtask

    task automatic t_basic_pulse();
        logic [7:0] d;
        clear_mon();
        host_wr(REG_A, 8'h01);
        host_rd(REG_A, d);
        chk("R4", "reset bit readback", d, 8'h25);
        wait_cyc(DLY + PW + 20);
        chk("R5", "pulse count", pulse_cnt, 1);
        chk("R5", "pulse delay", first_low - wr_cyc, DLY);
        chk("R5", "pulse width", low_cnt, PW);
    endtask

    task automatic t_rearm();
        clear_mon();
        host_wr(REG_A, 8'h01);           // bit already 1
        wait_cyc(DLY + PW + 20);
        chk("R6", "no pulse on repeated 1", pulse_cnt, 0);
        host_wr(REG_A, 8'h00);
        clear_mon();
        host_wr(REG_A, 8'h01);
        wait_cyc(DLY + PW + 20);
        chk("R6", "pulse after clear", pulse_cnt, 1);
        chk("R6", "re-armed pulse delay", first_low - wr_cyc, DLY);
        host_wr(REG_A, 8'h00);
    endtask

    task automatic t_enable_off();
        logic [7:0] d;
        fast_rst_en = 1'b0;
        clear_mon();
        host_wr(REG_A, 8'h01);
        host_rd(REG_A, d);
        chk("R7", "bit stored while disabled", d, 8'h25);
        wait_cyc(DLY + PW + 20);
        chk("R7", "no pulse while disabled", pulse_cnt, 0);
        host_wr(REG_A, 8'h00);
        fast_rst_en = 1'b1;
    endtask

    task automatic t_interrupt();
        int start;
        logic [7:0] d;
        clear_mon();
        host_wr(REG_A, 8'h01);
        start = wr_cyc;
        wait_cyc(100);
        host_wr(REG_A, 8'h00);           // clear during wait phase
        host_wr(REG_A, 8'h01);           // 0->1 while busy
        wait_cyc(DLY + PW + 20);
        chk("R8", "cleared sequence still fires", pulse_cnt, 1);
        chk("R8", "delay kept", first_low - start, DLY);
        chk("R8", "width kept", low_cnt, PW);
        chk("R9", "no second sequence", pulse_cnt, 1);
        host_rd(REG_A, d);
        chk("R9", "bit left at 1", d, 8'h25);
        host_wr(REG_A, 8'h00);
        clear_mon();
        host_wr(REG_A, 8'h01);
        wait_cyc(DLY + 50);
        host_wr(REG_A, 8'h00);           // clear during low phase
        wait_cyc(PW + 20);
        chk("R8", "clear in low phase keeps width", low_cnt, PW);
    endtask

    task automatic t_polarity();
        @(negedge clk); kbc_rst_n = 1'b0; #1;
        chk("R10", "kbc reset passes active low", sys_rst_out, 0);
        @(negedge clk); rst_pol_hi = 1'b1; #1;
        chk("R10", "kbc reset inverted", sys_rst_out, 1);
        @(negedge clk); kbc_rst_n = 1'b1; #1;
        chk("R10", "inactive inverted", sys_rst_out, 0);
        clear_mon();
        host_wr(REG_A, 8'h01);
        wait_cyc(DLY + PW + 20);
        chk("R10", "inverted pulse count", pulse_cnt, 1);
        chk("R10", "inverted pulse width", low_cnt, PW);
        host_wr(REG_A, 8'h00);
        @(negedge clk); rst_pol_hi = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset_state();
        t_reserved_and_decode();
        t_gate();
        t_basic_pulse();
        t_rearm();
        t_enable_off();
        t_interrupt();
        t_polarity();
        wait_cyc(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule